// File: doc/BRIEF.md
# Set-Associative Tag Store with Rank-Counter LRU

This block keeps the tags and valid bits of a set-associative cache and decides, on every lookup, whether the block address is present and which way it occupies. Each way of each set holds a small rank counter. Together, the counters of a set order its ways from least recently used (rank zero) to most recently used (rank `WAYS-1`). One lookup can be issued per clock cycle. The result appears one cycle later with a valid strobe: hit or miss, the way that was touched, and, on a miss, whether the replaced way held a live line.

The set is chosen by the low bits of the block address. The entire block address is kept as the tag. On a miss, the block installs the new address in the least recently used way immediately, so the next lookup already sees it. Data arrays, write-back and bus traffic belong to the surrounding cache.

Top module: `cache_tag_lru`

## Requirements
- R1: `SETS` and `WAYS` are powers of two with `WAYS >= 1` and `SETS >= 2`. The set of a lookup is `req_addr[log2(SETS)-1:0]`, so addresses in different sets never affect each other.
- R2: The whole `req_addr` is stored as the tag. A lookup hits only when a valid way of its set holds exactly that address. Addresses that share the set bits but differ elsewhere are distinct lines.
- R3: After reset, every way is invalid and way j of every set has rank j. As a result, the first `WAYS` misses to a set fill ways 0, 1, ..., `WAYS-1` in that order, and each reports `rsp_evict = 0`.
- R4: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid = 1` outside reset. `rsp_hit`, `rsp_way` and `rsp_evict` describe that lookup. A lookup in the cycle directly after another one sees all the updates made by the first.
- R5: On a hit to way i, every way of the set whose rank is above the rank of way i loses one, and way i gets rank `WAYS-1`. `rsp_way = i`.
- R6: On a miss, every way of the set with a nonzero rank loses one. The way with rank zero receives the address, becomes valid and gets rank `WAYS-1`. `rsp_way` names that way.
- R7: `rsp_evict` is 1 only for a miss whose replaced way was valid before the lookup. It is 0 for a hit and for a fill into an invalid way.
- R8: The ranks of the ways in every set are always a permutation of 0 to `WAYS-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request this cycle |
| req_addr | input | AW | Block address of the lookup |
| rsp_valid | output | 1 | Result of last cycle's lookup is present |
| rsp_hit | output | 1 | Lookup found a valid matching way |
| rsp_way | output | log2(WAYS) (min 1) | Way hit or filled |
| rsp_evict | output | 1 | Miss replaced a previously valid way |

## Verification
The hardest state to reach is a full set where the recency order has been shuffled by hits and then disturbed by an eviction. In that state, the victim differs from the fill order, and a hit to a middle-ranked way must leave the lower ranks untouched. The stimulus reaches it through a long pseudo-random stream over a 64-entry address space that maps onto only 16 lines. A reference model in the bench applies the rank rules to predict every response. Before that stream, directed fills, a hit and an eviction on one set pin down the reset ordering.

// File: rtl/cache_tag_lru.sv
module cache_tag_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int AW   = 20,
  localparam int SB  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WB  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [WB-1:0] rsp_way,
  output logic          rsp_evict
);

  localparam logic [WB-1:0] TOP = WB'(WAYS - 1);

  if (WAYS < 1 || SETS < 2 || (SETS & (SETS - 1)) != 0 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_cfg
    $error("cache_tag_lru: SETS and WAYS must be powers of two, SETS >= 2");
  end

  logic [AW-1:0] tag_q  [SETS][WAYS];
  logic [WAYS-1:0] vld_q [SETS];
  logic [WB-1:0] rank_q [SETS][WAYS];

  logic [SB-1:0] rsp_set;
  logic [AW-1:0] rsp_tag;

  wire [SB-1:0] set = req_addr[SB-1:0];

  logic [WAYS-1:0] hit_vec;
  logic            hit;
  logic [WB-1:0]   hway, zway, way, hrank;
  logic [WB-1:0]   nr [WAYS];

  always_comb begin
    hway = '0;
    zway = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[set][w] && (tag_q[set][w] == req_addr);
      if (hit_vec[w]) hway = WB'(w);
      if (rank_q[set][w] == '0) zway = WB'(w);
    end
    hit   = |hit_vec;
    way   = hit ? hway : zway;
    hrank = rank_q[set][hway];
    for (int w = 0; w < WAYS; w++) begin
      if (WB'(w) == way)
        nr[w] = TOP;
      else if (hit)
        nr[w] = (rank_q[set][w] > hrank) ? rank_q[set][w] - 1'b1 : rank_q[set][w];
      else
        nr[w] = (rank_q[set][w] != '0) ? rank_q[set][w] - 1'b1 : rank_q[set][w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_evict <= 1'b0;
      rsp_set   <= '0;
      rsp_tag   <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) rank_q[s][w] <= WB'(w);
      end
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit   <= hit;
        rsp_way   <= way;
        rsp_evict <= !hit && vld_q[set][zway];
        rsp_set   <= set;
        rsp_tag   <= req_addr;
        for (int w = 0; w < WAYS; w++) rank_q[set][w] <= nr[w];
        if (!hit) begin
          tag_q[set][zway] <= req_addr;
          vld_q[set][zway] <= 1'b1;
        end
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R4
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R4
  AST_USED_WAY_MRU: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rank_q[rsp_set][rsp_way] == TOP); // R5
  AST_USED_WAY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> vld_q[rsp_set][rsp_way] && tag_q[rsp_set][rsp_way] == rsp_tag); // R6

  for (genvar g = 0; g < SETS; g++) begin : g_perm
    logic [WAYS-1:0] seen;
    always_comb begin
      seen = '0;
      for (int w = 0; w < WAYS; w++) seen[rank_q[g][w]] = 1'b1;
    end
    AST_RANK_PERM: assert property (@(posedge clk) disable iff (rst)
      $countones(seen) == WAYS); // R8
  end

endmodule

// File: tb/tb_cache_tag_lru.sv
module tb_cache_tag_lru;
  localparam int CLK  = 10;
  localparam int SETS = 4;
  localparam int WAYS = 4;
  localparam int AW   = 6;
  localparam int WB   = 2;

  logic          clk = 0;
  logic          rst = 1;
  logic          req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid, rsp_hit, rsp_evict;
  logic [WB-1:0] rsp_way;

  int tests = 0;
  int fails = 0;

  int m_tag  [SETS][WAYS];
  bit m_val  [SETS][WAYS];
  int m_rank [SETS][WAYS];

  always #(CLK/2) clk = ~clk;

  cache_tag_lru #(.SETS(SETS), .WAYS(WAYS), .AW(AW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_evict(rsp_evict));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(input int a, output bit h, output int wy, output bit ev);
    int s = a % SETS;
    int hr;
    h = 0; wy = 0; ev = 0;
    for (int w = 0; w < WAYS; w++)
      if (m_val[s][w] && m_tag[s][w] == a) begin h = 1; wy = w; end
    if (h) begin
      hr = m_rank[s][wy];
      for (int w = 0; w < WAYS; w++)
        if (m_rank[s][w] > hr) m_rank[s][w]--;
    end else begin
      for (int w = 0; w < WAYS; w++)
        if (m_rank[s][w] == 0) wy = w;
      ev = m_val[s][wy];
      for (int w = 0; w < WAYS; w++)
        if (m_rank[s][w] != 0) m_rank[s][w]--;
      m_tag[s][wy] = a;
      m_val[s][wy] = 1;
    end
    m_rank[s][wy] = WAYS - 1;
  endtask

  task automatic access(input int a);
    bit h, ev;
    int wy;
    model(a, h, wy, ev);
    req_valid = 1;
    req_addr  = AW'(a);
    @(negedge clk);
    check("R4 rsp_valid", int'(rsp_valid), 1);
    check("R2 hit", int'(rsp_hit), int'(h));
    check(h ? "R5 hit way" : "R6 fill way", int'(rsp_way), wy);
    check("R7 evict", int'(rsp_evict), int'(ev));
  endtask

  task automatic idle();
    req_valid = 0;
    @(negedge clk);
    check("R4 idle", int'(rsp_valid), 0);
  endtask

  initial begin
    #(CLK * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lf = 32'h1234_5678;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_val[s][w] = 0; m_tag[s][w] = 0; m_rank[s][w] = w;
      end
    req_valid = 1;
    repeat (3) @(negedge clk);
    check("R4 reset rsp_valid", int'(rsp_valid), 0);
    rst = 0;
    req_valid = 0;
    @(negedge clk);
    check("R4 post-reset idle", int'(rsp_valid), 0);

    // R3: cold fills of set 1 go to ways 0..3, no eviction
    for (int k = 0; k < WAYS; k++) begin
      access(1 + 4 * k);
      check("R3 cold fill order", int'(rsp_way), k);
    end
    idle();
    // R1: another set is still cold
    access(2);
    check("R1 independent set way", int'(rsp_way), 0);
    check("R1 independent set evict", int'(rsp_evict), 0);
    // R5: hit on way 0 back-to-back, then fill evicts way 1 (now least recent)
    access(1);
    check("R5 hit way 0", int'(rsp_way), 0);
    access(33);
    check("R6 victim way 1", int'(rsp_way), 1);
    check("R7 eviction flagged", int'(rsp_evict), 1);
    // R2: address 5 was evicted, same set bits, must miss
    access(5);
    check("R2 evicted line misses", int'(rsp_hit), 0);
    idle();

    for (int n = 0; n < 4000; n++) begin
      lf = lf * 1103515245 + 12345;
      access((lf >>> 16) & 63);
      if (((lf >>> 24) & 15) == 0) idle();
    end
    idle();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule